// File: doc/BRIEF.md
# Nested-Loop Array Address Generator

This block issues one memory address per clock and walks a two-dimensional array in an order that software programs. The order is set by up to four nested loop levels. Each level has a trip count and a signed step that moves both the row index (i) and the column index (j). The walk also takes a start point, a base address, a row length, a column count and a boundary mode. Software loads these values through a small register-write port and then pulses `start`. No microcode is used: the loop state advances in hardware from the register contents alone.

Each address leaves the block with a valid flag, a zero-fill flag and a done marker. A stall input freezes every register, so the block can run in lock step with a downstream arithmetic pipeline. Both indexes pass through a boundary stage before the row-major address multiply. In wrap mode an index that falls just outside the array is folded back into range. In zero-fill mode the output is flagged so that the consumer can substitute zeros.

Top module: `nested_addr_gen`

## Requirements
- R1: Register writes (`cfg_we`, `cfg_addr`, `cfg_wdata`) set the program:
  - Level k (0 = innermost) has its trip count at offset 2k, bits [15:0].
  - Level k has its steps at offset 2k+1: row step in bits [15:0], column step in bits [31:16], both two's complement.
  - Offset 8 holds the start point: row in [15:0], column in [31:16], both signed.
  - Offset 9 holds the base address.
  - Offset 10 holds the row length in [15:0] and the column count in [31:16].
  - Offset 11 holds the mode in bit 0: 0 is wrap, 1 is zero-fill.
  - A write is ignored while a walk or its results are still in flight.
- R2: A `start` pulse while idle and not stalled begins a walk. A `start` while a walk is running is ignored.
- R3: Levels count like an odometer, with level 0 innermost. The n-th output uses the digits c_k of n taken in mixed radix of the trip counts. Its index is start + sum of c_k times step_k, for the row and the column separately.
- R4: The first level whose trip count is zero ends the nest, and the levels above it are ignored. If level 0 has a trip count of zero, a start gives a done marker and no address.
- R5: With no stall, one address appears per clock. The first address is visible two clock edges after the edge that samples `start`.
- R6: In wrap mode, a negative index has the span added and an index at or above the span has the span subtracted. The span is the row length for i and the column count for j. `out_zf` stays 0 in this mode.
- R7: In zero-fill mode, an output whose row or column index is out of range has `out_zf` = 1 and `out_addr` equal to the base address.
- R8: `out_addr` = column index × row length + row index + base address.
- R9: `out_done` is high together with the final address of a walk, once per walk. No valid output follows it.
- R10: While `stall` is high, all state and all outputs hold their values.
- R11: A level 0 with trip count 7 and row step 1, under a level 1 with trip count 25 and row step 2, gives 175 addresses. These form 25 windows of 7 consecutive elements, and each window starts 2 elements after the previous one.
- R12: After reset `out_valid`, `out_done`, `out_zf` and `out_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW (4) | Register offset |
| cfg_wdata | input | DATA_W (32) | Register write data |
| start | input | 1 | Begin a walk |
| stall | input | 1 | Freeze all state |
| out_valid | output | 1 | Address valid |
| out_addr | output | ADDR_W (32) | Memory address |
| out_zf | output | 1 | Output lies outside the array (zero-fill mode) |
| out_done | output | 1 | Final output of the walk |

## Verification
The bench builds the block with its default parameters: four loop levels, 16-bit counts and steps, 24-bit accumulators and 32-bit addresses. With four levels a single program can fill every level and exercise the carry from the innermost level through to the outermost. It can also place a zero trip count below a live level to show that the nest is cut off at that point. The 16-bit spans let the stimulus use negative steps and starts near an edge, so both correction directions of the wrap logic are reached. The same sequences are then replayed in zero-fill mode.

// File: rtl/nag_pkg.sv
package nag_pkg;
  // boundary handling selected by bit 0 of the mode register
  typedef enum logic {
    BND_WRAP = 1'b0,
    BND_ZERO = 1'b1
  } bnd_mode_e;

  // register offsets that follow the per-level pairs (level k uses 2k, 2k+1)
  localparam int LVL_STRIDE = 2;
  localparam int REL_START  = 0;
  localparam int REL_BASE   = 1;
  localparam int REL_GEOM   = 2;
  localparam int REL_MODE   = 3;
  localparam int N_GLOBAL   = 4;
endpackage

// File: rtl/nag_regs.sv
module nag_regs
  import nag_pkg::*;
#(
  parameter int NL     = 4,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CFG_AW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [DATA_W-1:0]           cfg_wdata,
  input  logic                        lock,
  output logic [NL-1:0][LEN_W-1:0]    len_q,
  output logic [NL-1:0][IDX_W-1:0]    di_q,
  output logic [NL-1:0][IDX_W-1:0]    dj_q,
  output logic [IDX_W-1:0]            i0_q,
  output logic [IDX_W-1:0]            j0_q,
  output logic [LEN_W-1:0]            rowlen_q,
  output logic [LEN_W-1:0]            ncols_q,
  output logic [ADDR_W-1:0]           base_q,
  output bnd_mode_e                   mode_q
);
  localparam int OFS_START = LVL_STRIDE * NL + REL_START;
  localparam int OFS_BASE  = LVL_STRIDE * NL + REL_BASE;
  localparam int OFS_GEOM  = LVL_STRIDE * NL + REL_GEOM;
  localparam int OFS_MODE  = LVL_STRIDE * NL + REL_MODE;

  logic wr_ok;
  assign wr_ok = cfg_we && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NL; k++) begin
        len_q[k] <= '0;
        di_q[k]  <= '0;
        dj_q[k]  <= '0;
      end
      i0_q     <= '0;
      j0_q     <= '0;
      rowlen_q <= '0;
      ncols_q  <= '0;
      base_q   <= '0;
      mode_q   <= BND_WRAP;
    end else if (wr_ok) begin
      for (int k = 0; k < NL; k++) begin
        if (cfg_addr == CFG_AW'(LVL_STRIDE * k))
          len_q[k] <= cfg_wdata[LEN_W-1:0];
        if (cfg_addr == CFG_AW'(LVL_STRIDE * k + 1)) begin
          di_q[k] <= cfg_wdata[IDX_W-1:0];
          dj_q[k] <= cfg_wdata[2*IDX_W-1:IDX_W];
        end
      end
      if (cfg_addr == CFG_AW'(OFS_START)) begin
        i0_q <= cfg_wdata[IDX_W-1:0];
        j0_q <= cfg_wdata[2*IDX_W-1:IDX_W];
      end
      if (cfg_addr == CFG_AW'(OFS_BASE))
        base_q <= cfg_wdata[ADDR_W-1:0];
      if (cfg_addr == CFG_AW'(OFS_GEOM)) begin
        rowlen_q <= cfg_wdata[LEN_W-1:0];
        ncols_q  <= cfg_wdata[2*LEN_W-1:LEN_W];
      end
      if (cfg_addr == CFG_AW'(OFS_MODE))
        mode_q <= bnd_mode_e'(cfg_wdata[0]);
    end
  end
endmodule

// File: rtl/nag_seq.sv
module nag_seq #(
  parameter int NL    = 4,
  parameter int LEN_W = 16,
  parameter int IDX_W = 16,
  parameter int ACC_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        stall,
  input  logic                        start,
  input  logic [NL-1:0][LEN_W-1:0]    len,
  input  logic [NL-1:0][IDX_W-1:0]    di,
  input  logic [NL-1:0][IDX_W-1:0]    dj,
  input  logic [IDX_W-1:0]            i0,
  input  logic [IDX_W-1:0]            j0,
  output logic                        busy,
  output logic                        emit_last,
  output logic                        emit_empty,
  output logic signed [ACC_W-1:0]     emit_i,
  output logic signed [ACC_W-1:0]     emit_j,
  output logic [NL-1:0]               step_vec,
  output logic [LEN_W-1:0]            cnt0,
  output logic [LEN_W-1:0]            len0
);
  // sign-extend a programmed step or start value to accumulator width
  function automatic logic signed [ACC_W-1:0] sx(input logic [IDX_W-1:0] v);
    return {{(ACC_W-IDX_W){v[IDX_W-1]}}, v};
  endfunction

  logic [NL-1:0][LEN_W-1:0] cnt;
  logic signed [ACC_W-1:0]  acc_i [NL];
  logic signed [ACC_W-1:0]  acc_j [NL];

  logic [NL-1:0] used, at_end, adv, step, wrap;
  logic          last;
  logic signed [ACC_W-1:0] nxt_i, nxt_j;

  always_comb begin
    used[0] = (len[0] != '0);
    for (int k = 1; k < NL; k++)
      used[k] = (len[k] != '0) && used[k-1];
    for (int k = 0; k < NL; k++)
      at_end[k] = (cnt[k] == len[k] - LEN_W'(1));
    adv[0] = 1'b1;
    for (int k = 1; k < NL; k++)
      adv[k] = adv[k-1] && at_end[k-1] && used[k];
    for (int k = 0; k < NL; k++) begin
      step[k] = adv[k] && !at_end[k];
      wrap[k] = adv[k] && at_end[k];
    end
    last  = (step == '0);
    nxt_i = acc_i[0];
    nxt_j = acc_j[0];
    for (int k = 0; k < NL; k++) begin
      if (step[k]) begin
        nxt_i = acc_i[k] + sx(di[k]);
        nxt_j = acc_j[k] + sx(dj[k]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      for (int k = 0; k < NL; k++) begin
        cnt[k]   <= '0;
        acc_i[k] <= '0;
        acc_j[k] <= '0;
      end
    end else if (!stall) begin
      if (!busy) begin
        if (start) begin
          busy <= used[0];
          for (int k = 0; k < NL; k++) begin
            cnt[k]   <= '0;
            acc_i[k] <= sx(i0);
            acc_j[k] <= sx(j0);
          end
        end
      end else begin
        if (last)
          busy <= 1'b0;
        for (int k = 0; k < NL; k++) begin
          if (step[k]) begin
            cnt[k]   <= cnt[k] + LEN_W'(1);
            acc_i[k] <= nxt_i;
            acc_j[k] <= nxt_j;
          end else if (wrap[k]) begin
            cnt[k]   <= '0;
            acc_i[k] <= nxt_i;
            acc_j[k] <= nxt_j;
          end
        end
      end
    end
  end

  assign emit_last  = busy && last;
  assign emit_empty = start && !busy && !used[0];
  assign emit_i     = acc_i[0];
  assign emit_j     = acc_j[0];
  assign step_vec   = busy ? step : '0;
  assign cnt0       = cnt[0];
  assign len0       = len[0];
endmodule

// File: rtl/nag_bound.sv
module nag_bound #(
  parameter int LEN_W = 16,
  parameter int ACC_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stall,
  input  logic                     in_valid,
  input  logic                     in_done,
  input  logic signed [ACC_W-1:0]  raw_i,
  input  logic signed [ACC_W-1:0]  raw_j,
  input  logic [LEN_W-1:0]         rowlen,
  input  logic [LEN_W-1:0]         ncols,
  input  logic                     zero_mode,
  output logic                     s1_valid,
  output logic                     s1_done,
  output logic                     s1_zf,
  output logic [LEN_W-1:0]         s1_i,
  output logic [LEN_W-1:0]         s1_j
);
  // returns {out_of_range, corrected index}; one fold toward the span
  function automatic logic [LEN_W:0] fold(input logic signed [ACC_W-1:0] raw,
                                          input logic [LEN_W-1:0] span);
    logic signed [ACC_W-1:0] s, t;
    logic oob;
    s = {{(ACC_W-LEN_W){1'b0}}, span};
    oob = 1'b1;
    if (raw < 0)
      t = raw + s;
    else if (raw >= s)
      t = raw - s;
    else begin
      t   = raw;
      oob = 1'b0;
    end
    return {oob, t[LEN_W-1:0]};
  endfunction

  logic [LEN_W:0] fi, fj;
  logic           oob_any;

  assign fi      = fold(raw_i, rowlen);
  assign fj      = fold(raw_j, ncols);
  assign oob_any = fi[LEN_W] || fj[LEN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_done  <= 1'b0;
      s1_zf    <= 1'b0;
      s1_i     <= '0;
      s1_j     <= '0;
    end else if (!stall) begin
      s1_valid <= in_valid;
      s1_done  <= in_done;
      s1_zf    <= in_valid && zero_mode && oob_any;
      if (zero_mode && oob_any) begin
        s1_i <= '0;
        s1_j <= '0;
      end else begin
        s1_i <= fi[LEN_W-1:0];
        s1_j <= fj[LEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nag_addr.sv
module nag_addr #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              s1_valid,
  input  logic              s1_done,
  input  logic              s1_zf,
  input  logic [LEN_W-1:0]  s1_i,
  input  logic [LEN_W-1:0]  s1_j,
  input  logic [LEN_W-1:0]  rowlen,
  input  logic [ADDR_W-1:0] base,
  output logic              out_valid,
  output logic              out_done,
  output logic              out_zf,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int PROD_W = 2 * LEN_W;

  // row-major placement: column * row length + row + base
  function automatic logic [ADDR_W-1:0] place(input logic [LEN_W-1:0] i,
                                              input logic [LEN_W-1:0] j,
                                              input logic [LEN_W-1:0] rl,
                                              input logic [ADDR_W-1:0] b);
    logic [PROD_W-1:0] p;
    p = {{LEN_W{1'b0}}, j} * {{LEN_W{1'b0}}, rl};
    return b + ADDR_W'(p) + ADDR_W'(i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      out_zf    <= 1'b0;
      out_addr  <= '0;
    end else if (!stall) begin
      out_valid <= s1_valid;
      out_done  <= s1_done;
      out_zf    <= s1_zf;
      out_addr  <= s1_valid ? place(s1_i, s1_j, rowlen, base) : '0;
    end
  end
endmodule

// File: rtl/nested_addr_gen.sv
module nested_addr_gen
  import nag_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int LEN_W      = 16,
  parameter int IDX_W      = 16,
  parameter int ACC_W      = 24,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  localparam int CFG_AW    = $clog2(LVL_STRIDE * NUM_LEVELS + N_GLOBAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              start,
  input  logic              stall,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_zf,
  output logic              out_done
);
  logic [NUM_LEVELS-1:0][LEN_W-1:0] len_q;
  logic [NUM_LEVELS-1:0][IDX_W-1:0] di_q, dj_q;
  logic [IDX_W-1:0]   i0_q, j0_q;
  logic [LEN_W-1:0]   rowlen_q, ncols_q;
  logic [ADDR_W-1:0]  base_q;
  bnd_mode_e          mode_q;
  logic               zero_mode;

  logic               seq_busy, seq_last, seq_empty;
  logic signed [ACC_W-1:0] seq_i, seq_j;
  logic [NUM_LEVELS-1:0]   step_vec;
  logic [LEN_W-1:0]   cnt0, len0;

  logic               s1_valid, s1_done, s1_zf;
  logic [LEN_W-1:0]   s1_i, s1_j;
  logic               cfg_lock;

  assign zero_mode = (mode_q == BND_ZERO);
  assign cfg_lock  = seq_busy | s1_valid | s1_done | out_valid | out_done;

  nag_regs #(
    .NL(NUM_LEVELS), .LEN_W(LEN_W), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lock(cfg_lock), .len_q(len_q), .di_q(di_q),
    .dj_q(dj_q), .i0_q(i0_q), .j0_q(j0_q), .rowlen_q(rowlen_q),
    .ncols_q(ncols_q), .base_q(base_q), .mode_q(mode_q)
  );

  nag_seq #(
    .NL(NUM_LEVELS), .LEN_W(LEN_W), .IDX_W(IDX_W), .ACC_W(ACC_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .stall(stall), .start(start),
    .len(len_q), .di(di_q), .dj(dj_q), .i0(i0_q), .j0(j0_q),
    .busy(seq_busy), .emit_last(seq_last), .emit_empty(seq_empty),
    .emit_i(seq_i), .emit_j(seq_j), .step_vec(step_vec),
    .cnt0(cnt0), .len0(len0)
  );

  nag_bound #(
    .LEN_W(LEN_W), .ACC_W(ACC_W)
  ) u_bound (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .in_valid(seq_busy), .in_done(seq_last | seq_empty),
    .raw_i(seq_i), .raw_j(seq_j), .rowlen(rowlen_q), .ncols(ncols_q),
    .zero_mode(zero_mode), .s1_valid(s1_valid), .s1_done(s1_done),
    .s1_zf(s1_zf), .s1_i(s1_i), .s1_j(s1_j)
  );

  nag_addr #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .s1_valid(s1_valid), .s1_done(s1_done), .s1_zf(s1_zf),
    .s1_i(s1_i), .s1_j(s1_j), .rowlen(rowlen_q), .base(base_q),
    .out_valid(out_valid), .out_done(out_done), .out_zf(out_zf),
    .out_addr(out_addr)
  );
endmodule

// File: rtl/nag_checker.sv
module nag_checker #(
  parameter int NL     = 4,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_zf,
  input logic              out_done,
  input logic              zero_mode,
  input logic [ADDR_W-1:0] base_q,
  input logic              seq_busy,
  input logic [NL-1:0]     step_vec,
  input logic [LEN_W-1:0]  cnt0,
  input logic [LEN_W-1:0]  len0
);
  // R9: a done marker lasts one accepted cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && !stall) |=> !out_done);

  // R10: stall freezes the outputs
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(out_valid) && $stable(out_addr) &&
               $stable(out_zf) && $stable(out_done)));

  // R6: wrap mode never flags zero fill
  a_r6_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !zero_mode) |-> !out_zf);

  // R7: a zero-filled output points at the base address
  a_r7_zero_at_base: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zf) |-> (out_addr == base_q));

  // R3: at most one level advances per cycle
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_vec));

  // R3: the innermost counter stays below its trip count
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (cnt0 < len0));
endmodule

bind nested_addr_gen nag_checker #(
  .NL(NUM_LEVELS), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
) u_nag_checker (
  .clk(clk), .rst_n(rst_n), .stall(stall), .out_valid(out_valid),
  .out_addr(out_addr), .out_zf(out_zf), .out_done(out_done),
  .zero_mode(zero_mode), .base_q(base_q), .seq_busy(seq_busy),
  .step_vec(step_vec), .cnt0(cnt0), .len0(len0)
);

// File: tb/test_nested_addr_gen.sv
module test_nested_addr_gen;
  localparam int NL     = 4;
  localparam int CFG_AW = 4;

  typedef struct packed {
    logic [3:0][15:0] len;
    logic [3:0][15:0] di;
    logic [3:0][15:0] dj;
    logic [15:0] i0;
    logic [15:0] j0;
    logic [15:0] rowlen;
    logic [15:0] ncols;
    logic [31:0] base;
    logic        zmode;
    logic        stall_on;
    logic [15:0] exp_n;
    logic [15:0] probe_n;
    logic [31:0] probe_addr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // R11 sliding window: 25 windows of 7, stride 2
    '{len:'{16'd0,16'd0,16'd25,16'd7}, di:'{16'd0,16'd0,16'd2,16'd1}, dj:'{16'd0,16'd0,16'd0,16'd0},
      i0:16'd0, j0:16'd0, rowlen:16'd64, ncols:16'd1, base:32'd1000, zmode:1'b0, stall_on:1'b0,
      exp_n:16'd175, probe_n:16'd7, probe_addr:32'd1002},
    // R3 transposed walk: column inner, row outer
    '{len:'{16'd0,16'd0,16'd5,16'd4}, di:'{16'd0,16'd0,16'd1,16'd0}, dj:'{16'd0,16'd0,16'd0,16'd1},
      i0:16'd0, j0:16'd0, rowlen:16'd5, ncols:16'd4, base:32'h100, zmode:1'b0, stall_on:1'b1,
      exp_n:16'd20, probe_n:16'd5, probe_addr:32'd262},
    // R6 wrap in both directions
    '{len:'{16'd0,16'd0,16'd3,16'd6}, di:'{16'd0,16'd0,16'd0,16'd1}, dj:'{16'd0,16'd0,16'hFFFF,16'd0},
      i0:16'd3, j0:16'd0, rowlen:16'd5, ncols:16'd3, base:32'd0, zmode:1'b0, stall_on:1'b0,
      exp_n:16'd18, probe_n:16'd8, probe_addr:32'd10},
    // R7 zero fill with the same walk
    '{len:'{16'd0,16'd0,16'd3,16'd6}, di:'{16'd0,16'd0,16'd0,16'd1}, dj:'{16'd0,16'd0,16'hFFFF,16'd0},
      i0:16'd3, j0:16'd0, rowlen:16'd5, ncols:16'd3, base:32'd500, zmode:1'b1, stall_on:1'b1,
      exp_n:16'd18, probe_n:16'd1, probe_addr:32'd504},
    // three levels: column, then two row strides
    '{len:'{16'd0,16'd3,16'd4,16'd5}, di:'{16'd0,16'd0,16'd2,16'd1}, dj:'{16'd0,16'd1,16'd0,16'd0},
      i0:16'd0, j0:16'd0, rowlen:16'd16, ncols:16'd4, base:32'd7, zmode:1'b0, stall_on:1'b0,
      exp_n:16'd60, probe_n:16'd59, probe_addr:32'd49},
    // all four levels used
    '{len:'{16'd2,16'd2,16'd3,16'd2}, di:'{16'd0,16'd4,16'd0,16'd1}, dj:'{16'd3,16'd0,16'd1,16'd0},
      i0:16'd0, j0:16'd0, rowlen:16'd8, ncols:16'd8, base:32'd0, zmode:1'b0, stall_on:1'b1,
      exp_n:16'd24, probe_n:16'd23, probe_addr:32'd45},
    // R4 zero trip count at level 2 hides level 3; negative row step
    '{len:'{16'd9,16'd0,16'd2,16'd4}, di:'{16'd0,16'd0,16'd0,16'hFFFF}, dj:'{16'd0,16'd0,16'd2,16'd0},
      i0:16'd3, j0:16'd1, rowlen:16'd10, ncols:16'd6, base:32'd20, zmode:1'b0, stall_on:1'b0,
      exp_n:16'd8, probe_n:16'd7, probe_addr:32'd50}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic start = 1'b0;
  logic stall = 1'b0;
  logic out_valid, out_zf, out_done;
  logic [31:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nested_addr_gen i_nested_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .stall(stall),
    .out_valid(out_valid), .out_addr(out_addr), .out_zf(out_zf),
    .out_done(out_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent model: digits of n in mixed radix, then modulo or range test
  function automatic logic [32:0] model(input vec_t v, input int n);
    int rem, c, ii, jj, rl, nc;
    bit oob;
    rem = n;
    ii = int'(signed'(v.i0));
    jj = int'(signed'(v.j0));
    for (int k = 0; k < NL; k++) begin
      if (v.len[k] == 0) break;
      c   = rem % int'(v.len[k]);
      rem = rem / int'(v.len[k]);
      ii += c * int'(signed'(v.di[k]));
      jj += c * int'(signed'(v.dj[k]));
    end
    rl  = int'(v.rowlen);
    nc  = int'(v.ncols);
    oob = (ii < 0) || (ii >= rl) || (jj < 0) || (jj >= nc);
    if (v.zmode) begin
      if (oob) return {1'b1, v.base};
    end else begin
      ii = ((ii % rl) + rl) % rl;
      jj = ((jj % nc) + nc) % nc;
    end
    return {1'b0, v.base + 32'(jj * rl + ii)};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_vec(input vec_t v);
    for (int k = 0; k < NL; k++) begin
      wr(2 * k, {16'd0, v.len[k]});
      wr(2 * k + 1, {v.dj[k], v.di[k]});
    end
    wr(8, {v.j0, v.i0});
    wr(9, v.base);
    wr(10, {v.ncols, v.rowlen});
    wr(11, {31'd0, v.zmode});
  endtask

  task automatic run_vec(input vec_t v, input bit inject, input bit prog, input string tag);
    int got, cyc, first_c, last_c;
    bit prev_st, st;
    logic [32:0] e;
    logic [31:0] pa;
    logic pv, pz, pd;
    if (prog) program_vec(v);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; cyc = 0; first_c = -1; last_c = -1; prev_st = 0;
    pa = '0; pv = 0; pz = 0; pd = 0;
    while (got < int'(v.exp_n) && cyc < 3000) begin
      if (prev_st)
        chk(out_valid == pv && out_addr == pa && out_zf == pz && out_done == pd,
            "R10", {tag, " stall hold"}, longint'(out_addr), longint'(pa));
      if (inject && cyc == 3) begin
        cfg_we = 1'b1; cfg_addr = CFG_AW'(9); cfg_wdata = 32'd5000;
      end
      if (inject && cyc == 4) begin
        cfg_addr = CFG_AW'(0); cfg_wdata = 32'd3; start = 1'b1;
      end
      if (inject && cyc == 5) begin
        cfg_we = 1'b0; start = 1'b0;
      end
      st = v.stall_on && (cyc % 4 == 2);
      stall = st;
      if (out_valid && !st) begin
        e = model(v, got);
        chk(out_addr == e[31:0], "R8", {tag, " address"}, longint'(out_addr), longint'(e[31:0]));
        chk(out_zf == e[32], "R7", {tag, " zero-fill flag"}, longint'(out_zf), longint'(e[32]));
        chk(out_done == (got == int'(v.exp_n) - 1), "R9", {tag, " done marker"},
            longint'(out_done), longint'(got == int'(v.exp_n) - 1));
        if (got == int'(v.probe_n))
          chk(out_addr == v.probe_addr, "R11", {tag, " probe address"},
              longint'(out_addr), longint'(v.probe_addr));
        if (first_c < 0) first_c = cyc;
        last_c = cyc;
        got++;
      end
      prev_st = st; pa = out_addr; pv = out_valid; pz = out_zf; pd = out_done;
      @(negedge clk);
      cyc++;
    end
    stall = 1'b0;
    chk(got == int'(v.exp_n), "R3", {tag, " output count"}, got, int'(v.exp_n));
    if (!v.stall_on && !inject) begin
      chk(first_c == 2, "R5", {tag, " first address latency"}, first_c, 2);
      chk(last_c - first_c == int'(v.exp_n) - 1, "R5", {tag, " one per cycle"},
          last_c - first_c, int'(v.exp_n) - 1);
    end
    for (int w = 0; w < 4; w++) begin
      chk(!out_valid, "R9", {tag, " nothing after done"}, longint'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int dones, valids;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!out_valid && !out_done && !out_zf && out_addr == 0, "R12", "reset outputs",
        longint'({out_valid, out_done, out_zf}), 0);

    // table walk
    for (int t = 0; t < NV; t++)
      run_vec(VECS[t], 1'b0, 1'b1, $sformatf("vec%0d", t));

    // R1 and R2: writes and a second start while running are ignored
    run_vec(VECS[0], 1'b1, 1'b1, "locked run");
    run_vec(VECS[0], 1'b0, 1'b0, "rerun after locked writes");

    // R4: zero trip count at level 0 yields only a done marker
    wr(0, 32'd0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0; valids = 0;
    for (int w = 0; w < 6; w++) begin
      if (out_done) dones++;
      if (out_valid) valids++;
      @(negedge clk);
    end
    chk(dones == 1, "R4", "empty walk done count", dones, 1);
    chk(valids == 0, "R4", "empty walk valid count", valids, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule